// File: doc/BRIEF.md
# SPI Slave with FIFO Buffering

This block is the slave end of a four-wire serial link. An external master supplies the bit clock, the slave-select strobe (active low) and the master-to-slave data line. The block returns data on the slave-to-master line together with an output-enable for the pad. All serial inputs are brought into the system clock domain through two-stage synchronisers. Clock edges, select edges and data samples are detected and acted on there, so the whole design runs on one clock.

Words to send are written ahead of time into a transmit FIFO. Each word taken off the line is placed in a receive FIFO, where the system side reads it. The clock polarity and phase are configuration inputs. They must match the master and may only change while the select is high. The word length is a parameter. Two policy inputs decide what happens when the transmit FIFO is empty at the start of a word, and when the receive FIFO is full at the end of one. Sticky flags record each of these events.

Top module: `spi_fifo_slave`

## Requirements
- R1: While reset is applied and just after it, `miso_oe` is 0, `tx_full` is 0, `rx_empty` is 1, and both status flags are 0.
- R2: `miso_oe` is 1 exactly when `ss_n` is low, lagging `ss_n` by two system clock edges because of the synchroniser.
- R3: With `cfg_cpha`=0, bits go out MSB first. The first bit of a word is on `miso` before the first SCLK edge after the select falls. MOSI is sampled on the leading edge, which is the edge that leaves the `cfg_cpol` level. `miso` advances on the trailing edge.
- R4: With `cfg_cpha`=1, `miso` advances on the leading edge and MOSI is sampled on the trailing edge. Bits are MSB first.
- R5: While the select stays low, each group of WORD_W sampling edges completes one word. That word is pushed into the receive FIFO, and the next transmit word follows without a gap.
- R6: A transmit word leaves the FIFO on the first sampling edge of its word. A write while `tx_full` is 1 is ignored.
- R7: If the transmit FIFO is empty when a word starts, the word sent is all zeros when `cfg_urun_hold`=0. When `cfg_urun_hold`=1 it is the previous word sent, which is zero if no word has been sent yet. In both cases `urun_flag` is set.
- R8: If the receive FIFO is full when a word completes, `orun_flag` is set. With `cfg_orun_ovw`=0 the new word is discarded. With `cfg_orun_ovw`=1 it replaces the most recently stored entry.
- R9: Both flags stay set until `flag_clr` is pulsed. A set in the same cycle as a clear wins.
- R10: If the select rises partway through a word, the partial receive word is dropped and the bit count restarts. The transmit word already taken for that word is not sent again.
- R11: SCLK edges while the select is high have no effect on either FIFO or on the data that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_urun_hold | input | 1 | Underrun policy: 0 sends zeros, 1 repeats the previous word |
| cfg_orun_ovw | input | 1 | Overrun policy: 0 discards the new word, 1 overwrites the newest entry |
| flag_clr | input | 1 | Clears both status flags |
| tx_wr | input | 1 | Transmit FIFO write strobe |
| tx_data | input | WORD_W | Word to transmit |
| tx_full | output | 1 | Transmit FIFO full |
| rx_rd | input | 1 | Receive FIFO read strobe |
| rx_data | output | WORD_W | Oldest received word |
| rx_empty | output | 1 | Receive FIFO empty |
| sclk | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| ss_n | input | 1 | Slave select, active low |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the `miso` pad |
| urun_flag | output | 1 | Sticky transmit underrun flag |
| orun_flag | output | 1 | Sticky receive overrun flag |

## Verification
Every serial event reaches the registers three system edges after the pin changes: two synchroniser stages, then the edge detector feeding the state update. So `miso` settles three cycles after a driving edge, and a received word or a flag appears three cycles after its final sampling edge. `miso_oe` is compared on every clock with the select delayed by two edges. The emulated master holds each SCLK phase for six clocks and reads `miso` at the end of the phase, after the three-cycle settling time. The receive FIFO and the flags are read only after the select has risen and the pipeline has drained.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic urun_hold;
    logic orun_ovw;
  } slv_cfg_t;

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic mosi,
  input  logic ss_n,
  input  logic cpol,
  input  logic cpha,
  output logic mosi_s,
  output logic ss_act,
  output logic ss_fall,
  output logic ss_rise,
  output logic drive_ev,
  output logic sample_ev
);
  // two synchroniser stages plus one history stage for edge detection
  logic [2:0] sclk_p, ss_p, sclk_p_n, ss_p_n;
  logic [1:0] mosi_p, mosi_p_n;
  logic       toggled, lead, trail;

  always_comb begin
    sclk_p_n = {sclk_p[1:0], sclk};
    ss_p_n   = {ss_p[1:0], ss_n};
    mosi_p_n = {mosi_p[0], mosi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      ss_p   <= '1;
      mosi_p <= '0;
    end else begin
      sclk_p <= sclk_p_n;
      ss_p   <= ss_p_n;
      mosi_p <= mosi_p_n;
    end
  end

  assign toggled   = sclk_p[1] ^ sclk_p[2];
  assign lead      = toggled && (sclk_p[1] != cpol);
  assign trail     = toggled && (sclk_p[1] == cpol);
  assign ss_act    = ~ss_p[1];
  assign ss_fall   = ss_p[2] & ~ss_p[1];
  assign ss_rise   = ~ss_p[2] & ss_p[1];
  assign drive_ev  = ss_act & (cpha ? lead : trail);
  assign sample_ev = ss_act & (cpha ? trail : lead);
  assign mosi_s    = mosi_p[1];
endmodule

// File: rtl/spi_slv_fifo.sv
module spi_slv_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         ovw_en,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_ptr_n, rd_ptr_n, wa;
  logic [AW:0]   cnt, cnt_n;
  logic          pop_ok, push_ok, ovw, we;

  assign full  = (cnt == FULL_CNT);
  assign empty = (cnt == '0);
  assign head  = mem[rd_ptr];

  always_comb begin
    pop_ok   = pop && !empty;
    push_ok  = push && (!full || pop_ok);
    ovw      = push && full && !pop_ok && ovw_en;
    we       = push_ok || ovw;
    wa       = ovw ? (wr_ptr - 1'b1) : wr_ptr;
    wr_ptr_n = push_ok ? wr_ptr + 1'b1 : wr_ptr;
    rd_ptr_n = pop_ok  ? rd_ptr + 1'b1 : rd_ptr;
    cnt_n    = cnt;
    if (push_ok && !pop_ok)      cnt_n = cnt + 1'b1;
    else if (pop_ok && !push_ok) cnt_n = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      cnt    <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= push_data;
  end
endmodule

// File: rtl/spi_slv_core.sv
module spi_slv_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mosi_s,
  input  logic         ss_fall,
  input  logic         ss_rise,
  input  logic         drive_ev,
  input  logic         sample_ev,
  input  logic         urun_hold,
  input  logic         tx_empty,
  input  logic [W-1:0] tx_head,
  output logic         tx_pop,
  output logic         urun_set,
  output logic         rx_push,
  output logic [W-1:0] rx_word,
  output logic         miso_bit
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W-1);

  logic [CW-1:0] bitcnt, bitcnt_n;
  logic          fresh, fresh_n;
  logic [W-1:0]  tx_sh, tx_sh_n, rx_sh, rx_sh_n, last_w, last_w_n, src_word;
  logic          restart, samp;

  assign restart  = ss_fall | ss_rise;
  assign samp     = sample_ev & ~restart;
  assign src_word = !tx_empty ? tx_head : (urun_hold ? last_w : '0);
  assign miso_bit = fresh ? src_word[W-1] : tx_sh[W-1];
  assign tx_pop   = samp & fresh & ~tx_empty;
  assign urun_set = samp & fresh & tx_empty;
  assign rx_push  = samp & (bitcnt == LAST);
  assign rx_word  = {rx_sh[W-2:0], mosi_s};

  always_comb begin
    bitcnt_n = bitcnt;
    fresh_n  = fresh;
    tx_sh_n  = tx_sh;
    rx_sh_n  = rx_sh;
    last_w_n = last_w;
    if (restart) begin
      bitcnt_n = '0;
      fresh_n  = 1'b1;
    end else if (sample_ev) begin
      rx_sh_n = rx_word;
      if (fresh) begin
        tx_sh_n  = src_word;
        last_w_n = src_word;
        fresh_n  = 1'b0;
      end
      if (bitcnt == LAST) begin
        bitcnt_n = '0;
        fresh_n  = 1'b1;
      end else begin
        bitcnt_n = bitcnt + 1'b1;
      end
    end else if (drive_ev && !fresh) begin
      tx_sh_n = {tx_sh[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0;
      fresh  <= 1'b1;
      tx_sh  <= '0;
      rx_sh  <= '0;
      last_w <= '0;
    end else begin
      bitcnt <= bitcnt_n;
      fresh  <= fresh_n;
      tx_sh  <= tx_sh_n;
      rx_sh  <= rx_sh_n;
      last_w <= last_w_n;
    end
  end
endmodule

// File: rtl/spi_fifo_slave.sv
module spi_fifo_slave #(
  parameter int WORD_W   = 8,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_urun_hold,
  input  logic              cfg_orun_ovw,
  input  logic              flag_clr,
  input  logic              tx_wr,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_full,
  input  logic              rx_rd,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_empty,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              ss_n,
  output logic              miso,
  output logic              miso_oe,
  output logic              urun_flag,
  output logic              orun_flag
);
  import spi_slv_pkg::*;

  slv_cfg_t    cfg;
  logic [1:0]  rst_q;
  logic        rst_i_n;
  logic        mosi_s, ss_act, ss_fall, ss_rise, drive_ev, sample_ev;
  logic        tx_empty, tx_pop, urun_set, rx_push, orun_set;
  logic [WORD_W-1:0] tx_head, rx_word;
  logic        urun_n, orun_n;

  assign cfg = '{cpol: cfg_cpol, cpha: cfg_cpha,
                 urun_hold: cfg_urun_hold, orun_ovw: cfg_orun_ovw};

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i_n = rst_q[1];

  spi_slv_sync u_sync (
    .clk(clk), .rst_n(rst_i_n), .sclk(sclk), .mosi(mosi), .ss_n(ss_n),
    .cpol(cfg.cpol), .cpha(cfg.cpha), .mosi_s(mosi_s), .ss_act(ss_act),
    .ss_fall(ss_fall), .ss_rise(ss_rise), .drive_ev(drive_ev),
    .sample_ev(sample_ev)
  );

  spi_slv_fifo #(.W(WORD_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_i_n), .push(tx_wr), .push_data(tx_data),
    .ovw_en(1'b0), .pop(tx_pop), .head(tx_head), .full(tx_full),
    .empty(tx_empty)
  );

  spi_slv_core #(.W(WORD_W)) u_core (
    .clk(clk), .rst_n(rst_i_n), .mosi_s(mosi_s), .ss_fall(ss_fall),
    .ss_rise(ss_rise), .drive_ev(drive_ev), .sample_ev(sample_ev),
    .urun_hold(cfg.urun_hold), .tx_empty(tx_empty), .tx_head(tx_head),
    .tx_pop(tx_pop), .urun_set(urun_set), .rx_push(rx_push),
    .rx_word(rx_word), .miso_bit(miso)
  );

  spi_slv_fifo #(.W(WORD_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_i_n), .push(rx_push), .push_data(rx_word),
    .ovw_en(cfg.orun_ovw), .pop(rx_rd), .head(rx_data), .full(rx_full_w),
    .empty(rx_empty)
  );

  logic rx_full_w;
  assign orun_set = rx_push & rx_full_w & ~(rx_rd & ~rx_empty);
  assign miso_oe  = ss_act;

  always_comb begin
    urun_n = (urun_flag & ~flag_clr) | urun_set;
    orun_n = (orun_flag & ~flag_clr) | orun_set;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      urun_flag <= 1'b0;
      orun_flag <= 1'b0;
    end else begin
      urun_flag <= urun_n;
      orun_flag <= orun_n;
    end
  end
endmodule

// File: rtl/spi_fifo_slave_chk.sv
module spi_fifo_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic ss_n,
  input logic miso_oe,
  input logic flag_clr,
  input logic urun_flag,
  input logic orun_flag,
  input logic tx_full,
  input logic tx_pop,
  input logic rx_empty,
  input logic rx_push
);
  AST_OE_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_n && $past(ss_n)) |=> !miso_oe); // R2

  AST_URUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (urun_flag && !flag_clr) |=> urun_flag); // R9

  AST_ORUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (orun_flag && !flag_clr) |=> orun_flag); // R9

  AST_RX_FILLS_ONLY_BY_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty && !rx_push) |=> rx_empty); // R5

  AST_TX_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && !tx_pop) |=> tx_full); // R6
endmodule

bind spi_fifo_slave spi_fifo_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .miso_oe(miso_oe),
  .flag_clr(flag_clr), .urun_flag(urun_flag), .orun_flag(orun_flag),
  .tx_full(tx_full), .tx_pop(tx_pop), .rx_empty(rx_empty),
  .rx_push(rx_push)
);

// File: tb/spi_fifo_slave_bench.sv
module spi_fifo_slave_bench;
  localparam int W = 8;
  localparam int TXD = 4;
  localparam int RXD = 4;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n, cpol, cpha, uhold, oovw, flag_clr, tx_wr, rx_rd;
  logic sclk, mosi, ss_n;
  logic [W-1:0] tx_data;
  logic tx_full, rx_empty, miso, miso_oe, urun_flag, orun_flag;
  logic [W-1:0] rx_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit [W-1:0] txq[$];
  bit [W-1:0] rxq[$];
  bit [W-1:0] last_sent = '0;
  bit exp_urun = 0, exp_orun = 0;
  logic p1, p2;

  always #5 clk = ~clk;

  spi_fifo_slave #(.WORD_W(W), .TX_DEPTH(TXD), .RX_DEPTH(RXD)) u_spi_fifo_slave (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cpol), .cfg_cpha(cpha),
    .cfg_urun_hold(uhold), .cfg_orun_ovw(oovw), .flag_clr(flag_clr),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full), .rx_rd(rx_rd),
    .rx_data(rx_data), .rx_empty(rx_empty), .sclk(sclk), .mosi(mosi),
    .ss_n(ss_n), .miso(miso), .miso_oe(miso_oe), .urun_flag(urun_flag),
    .orun_flag(orun_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // select delayed by two edges: expected output enable (R2)
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin p1 <= 1'b1; p2 <= 1'b1; end
    else begin p1 <= ss_n; p2 <= p1; end

  always @(negedge clk)
    if (rst_n && !done) chk(miso_oe == !p2, "R2 oe", miso_oe, !p2);

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_tx(input bit [W-1:0] w);
    tx_wr = 1'b1; tx_data = w; tick(1); tx_wr = 1'b0;
    if (txq.size() < TXD) txq.push_back(w);
  endtask

  task automatic begin_tr();
    sclk = cpol; tick(4); ss_n = 1'b0; tick(HALF);
  endtask

  task automatic end_tr();
    tick(HALF); ss_n = 1'b1; tick(8);
  endtask

  // one word (or nb leading bits of it) as master; checks miso each bit
  task automatic xfer(input bit [W-1:0] mo, input int nb);
    bit [W-1:0] ex;
    if (txq.size() > 0) ex = txq.pop_front();
    else begin ex = uhold ? last_sent : '0; exp_urun = 1; end
    last_sent = ex;
    for (int b = 0; b < nb; b++) begin
      if (!cpha) begin
        mosi = mo[W-1-b]; tick(HALF);
        chk(miso == ex[W-1-b], "R3 miso bit", miso, ex[W-1-b]);
        sclk = ~cpol; tick(HALF); sclk = cpol;
      end else begin
        sclk = ~cpol; mosi = mo[W-1-b]; tick(HALF);
        chk(miso == ex[W-1-b], "R4 miso bit", miso, ex[W-1-b]);
        sclk = cpol; tick(HALF);
      end
    end
    if (nb == W) begin
      if (rxq.size() < RXD) rxq.push_back(mo);
      else begin exp_orun = 1; if (oovw) rxq[rxq.size()-1] = mo; end
    end
  endtask

  task automatic drain_rx(input string req);
    while (!rx_empty) begin
      bit [W-1:0] e;
      e = (rxq.size() > 0) ? rxq.pop_front() : '1;
      chk(rx_data == e, req, rx_data, e);
      rx_rd = 1'b1; tick(1); rx_rd = 1'b0; tick(1);
    end
    chk(rxq.size() == 0, {req, " count"}, 0, rxq.size());
  endtask

  task automatic flags(input string req);
    chk(urun_flag == exp_urun, {req, " urun"}, urun_flag, exp_urun);
    chk(orun_flag == exp_orun, {req, " orun"}, orun_flag, exp_orun);
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0; tick(1);
    exp_urun = 0; exp_orun = 0;
    flags("R9 clear");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cpol = 0; cpha = 0; uhold = 0; oovw = 0; flag_clr = 0;
    tx_wr = 0; rx_rd = 0; sclk = 0; mosi = 0; ss_n = 1; tx_data = '0;
    tick(3);
    chk(miso_oe == 0, "R1 oe in reset", miso_oe, 0);
    rst_n = 1; tick(4);
    chk(tx_full == 0, "R1 tx_full", tx_full, 0);
    chk(rx_empty == 1, "R1 rx_empty", rx_empty, 1);
    flags("R1");

    // R3 / R5: mode 0, two back-to-back words
    push_tx(8'hA5); push_tx(8'h3C);
    begin_tr(); xfer(8'h81, W); xfer(8'h7E, W); end_tr();
    drain_rx("R5 rx mode0"); flags("R7 none");

    // R4: polarity 1, phase 1
    cpol = 1; cpha = 1;
    push_tx(8'h0F); push_tx(8'hF0);
    begin_tr(); xfer(8'hC3, W); xfer(8'h18, W); end_tr();
    drain_rx("R5 rx mode3");

    // R11: SCLK toggling while deselected
    for (int i = 0; i < 6; i++) begin sclk = ~sclk; tick(HALF); end
    push_tx(8'h66);
    begin_tr(); xfer(8'h5A, W); end_tr();
    drain_rx("R11 rx after idle clocks");

    // R7: underrun repeating the previous word
    uhold = 1;
    begin_tr(); xfer(8'h11, W); end_tr();
    flags("R7 hold"); tick(5); flags("R9 sticky");
    clear_flags(); drain_rx("R7 rx");

    // R7: underrun sending zeros
    uhold = 0;
    begin_tr(); xfer(8'h22, W); end_tr();
    flags("R7 zero"); clear_flags(); drain_rx("R7 rx zero");

    // R10: select released after three bits
    cpol = 0; cpha = 0;
    push_tx(8'h55); push_tx(8'h99);
    begin_tr(); xfer(8'hFF, 3); end_tr();
    chk(rx_empty == 1, "R10 partial dropped", rx_empty, 1);
    begin_tr(); xfer(8'hE7, W); end_tr();
    drain_rx("R10 rx next word");

    // R8: overrun discarding the new word
    begin_tr();
    for (int i = 1; i <= 5; i++) xfer(W'(i), W);
    end_tr();
    flags("R8 discard"); drain_rx("R8 discard rx"); clear_flags();

    // R8: overrun overwriting the newest entry
    oovw = 1;
    begin_tr();
    for (int i = 1; i <= 5; i++) xfer(W'(8'h10 + i), W);
    end_tr();
    flags("R8 overwrite"); drain_rx("R8 overwrite rx"); clear_flags();
    oovw = 0;

    // R6: writes beyond capacity are ignored
    for (int i = 1; i <= 5; i++) push_tx(W'(8'h40 + i));
    tick(1);
    chk(tx_full == 1, "R6 tx_full", tx_full, 1);
    begin_tr();
    for (int i = 0; i < 5; i++) xfer(W'(8'h80 + i), W);
    end_tr();
    flags("R6 extra write dropped"); clear_flags();
    drain_rx("R6 rx");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule